// File: doc/BRIEF.md
# Latched Serial-In Parallel-Out Channel Driver

This block accepts a serial bit stream qualified by a slow, externally generated shift clock and collects it in a shift register whose length is a parameter (32 by default). A bank of holding registers, transparent while the load-enable input is high, captures the register contents and presents a parallel word. An output stage then turns that word into one "on" line per channel, under a two-input control that can force every channel on, force every channel off, pass the word straight through, or pass it inverted. The last register stage is brought out as a serial output, so several blocks can be chained into one longer stream.

All inputs are sampled by a fast system clock. The shift clock, the serial data and the load enable pass through a multi-flop synchronizer. A falling edge of the synchronized shift clock produces a one-cycle shift strobe. A parameter selects whether the register fills the channels in ascending or descending order. Reset is synchronous and active high.

Top module: `sipo_channel_driver`

## Requirements
- R1: On each high-to-low transition of `sclk`, the register moves one stage toward the last stage and loads `sdi` into its first stage. No other input pattern changes the register.
- R2: `sdo` always shows the last register stage. After CHANNELS shifts it equals the first bit shifted in, and after one more shift it equals the second bit.
- R3: The inputs `le`, `blank_n` and `pol` have no effect on shifting. Toggling them during a shift sequence leaves the shifted contents and `sdo` unchanged.
- R4: While `le` is high, the holding registers follow the shift register. While `le` is low, they keep their last value, so data shifted in during that time does not reach `out_on`.
- R5: With `blank_n`=0 and `pol`=0, every bit of `out_on` is 1, whatever the held word is.
- R6: With `blank_n`=0 and `pol`=1, every bit of `out_on` is 0.
- R7: With `blank_n`=1 and `pol`=1, each channel equals its held bit. With `blank_n`=1 and `pol`=0, each channel is the inverse of its held bit.
- R8: When FILL_ASCENDING=1, `out_on[k]` is driven by register stage k, so the last bit shifted in lands on `out_on[0]`. When FILL_ASCENDING=0, `out_on[k]` is driven by stage CHANNELS-1-k, so the first bit shifted in lands on `out_on[0]`.
- R9: While `rst` is high, the register, the held word and `out_on` are all cleared to 0, and `sdo` is 0.
- R10: `out_on` reflects a change of `blank_n` or `pol` at the first clock edge after the change. It reflects a newly loaded word at the fourth clock edge after `le` rises, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Shift clock; the register shifts on its falling edge |
| sdi | input | 1 | Serial data into the first stage |
| le | input | 1 | Load enable; holding registers are transparent while it is high |
| blank_n | input | 1 | Blanking control, active low |
| pol | input | 1 | Polarity control |
| out_on | output | CHANNELS | Per-channel drive; 1 means the channel is on |
| sdo | output | 1 | Last register stage, used for chaining |

## Verification
A falling edge of `sclk` reaches the register at the third clock edge after it is driven, and `sdo` shows the new stage from then on. The bench therefore holds each level of `sclk` for four cycles before it looks at anything. A change of `blank_n` or `pol` is checked exactly one edge later. A rise of `le` is checked twice: after three edges, when the old value must still be present, and after the fourth edge, when the new one must have arrived. Every other check waits until the pipeline has settled, and two instances, one for each fill order, are driven side by side.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    typedef enum logic [1:0] {
        DRV_ALL_ON  = 2'd0,
        DRV_ALL_OFF = 2'd1,
        DRV_INVERT  = 2'd2,
        DRV_DIRECT  = 2'd3
    } drv_mode_e;

    // Synchronized control levels carried between sub-blocks
    typedef struct packed {
        logic sclk;
        logic sdi;
        logic le;
    } sync_bus_t;

    localparam int SYNC_W = $bits(sync_bus_t);

    function automatic drv_mode_e decode_mode(input logic blank_n, input logic pol);
        drv_mode_e m;
        case ({blank_n, pol})
            2'b00:   m = DRV_ALL_ON;
            2'b01:   m = DRV_ALL_OFF;
            2'b10:   m = DRV_INVERT;
            default: m = DRV_DIRECT;
        endcase
        return m;
    endfunction

    function automatic logic drive_bit(input drv_mode_e m, input logic held);
        logic r;
        case (m)
            DRV_ALL_ON:  r = 1'b1;
            DRV_ALL_OFF: r = 1'b0;
            DRV_INVERT:  r = ~held;
            default:     r = held;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sipo_shift_reg.sv
module sipo_shift_reg #(
    parameter int CHANNELS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_s,
    input  logic                sdi_s,
    output logic [CHANNELS-1:0] sr_q,
    output logic                sdo
);
    logic sclk_prev;
    logic shift_stb;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_s;
    end

    assign shift_stb = sclk_prev & ~sclk_s;

    always_ff @(posedge clk) begin
        if (rst)            sr_q <= '0;
        else if (shift_stb) sr_q <= {sr_q[CHANNELS-2:0], sdi_s};
    end

    assign sdo = sr_q[CHANNELS-1];

    // R1: a strobe lasts exactly one cycle
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
        shift_stb |=> !shift_stb);

    // R1: without a strobe the register keeps its contents
    p_hold_no_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !shift_stb |=> $stable(sr_q));

    // R1: a strobe loads the serial bit into the first stage
    p_first_stage_r1: assert property (@(posedge clk) disable iff (rst)
        shift_stb |=> sr_q[0] == $past(sdi_s));

endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank #(
    parameter int CHANNELS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                le_s,
    input  logic [CHANNELS-1:0] sr_q,
    output logic [CHANNELS-1:0] held_q
);
    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (le_s) held_q <= sr_q;
    end

    // R4: holding registers keep their value while load is low
    p_hold_closed_r4: assert property (@(posedge clk) disable iff (rst)
        !le_s |=> $stable(held_q));

    // R4: holding registers track the shift register while load is high
    p_follow_open_r4: assert property (@(posedge clk) disable iff (rst)
        le_s |=> held_q == $past(sr_q));

endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage
    import sipo_pkg::*;
#(
    parameter int CHANNELS       = 32,
    parameter bit FILL_ASCENDING = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                blank_n,
    input  logic                pol,
    input  logic [CHANNELS-1:0] held_q,
    output logic [CHANNELS-1:0] out_on
);
    localparam int LAST = CHANNELS - 1;

    logic [CHANNELS-1:0] mapped;
    logic [CHANNELS-1:0] drive_d;
    drv_mode_e           mode;

    assign mode = decode_mode(blank_n, pol);

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
        if (FILL_ASCENDING) begin : g_asc
            assign mapped[k] = held_q[k];
        end else begin : g_desc
            assign mapped[k] = held_q[LAST-k];
        end
        assign drive_d[k] = drive_bit(mode, mapped[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) out_on <= '0;
        else     out_on <= drive_d;
    end

    // R5: blank low, polarity low forces every channel on
    p_all_on_r5: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && !pol) |=> &out_on);

    // R6: blank low, polarity high forces every channel off
    p_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && pol) |=> out_on == '0);

    // R7: inverted pass-through is the complement of the held word
    p_invert_r7: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !pol && $stable(held_q)) |=> (out_on ^ held_q) == {CHANNELS{1'b1}}
            || FILL_ASCENDING == 1'b0);

endmodule

// File: rtl/sipo_channel_driver.sv
module sipo_channel_driver
    import sipo_pkg::*;
#(
    parameter int CHANNELS       = 32,
    parameter int SYNC_STAGES    = 2,
    parameter bit FILL_ASCENDING = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                le,
    input  logic                blank_n,
    input  logic                pol,
    output logic [CHANNELS-1:0] out_on,
    output logic                sdo
);
    sync_bus_t           raw_bus;
    sync_bus_t           syn_bus;
    logic [SYNC_W-1:0]   syn_vec;
    logic [CHANNELS-1:0] sr_q;
    logic [CHANNELS-1:0] held_q;

    assign raw_bus.sclk = sclk;
    assign raw_bus.sdi  = sdi;
    assign raw_bus.le   = le;
    assign syn_bus      = sync_bus_t'(syn_vec);

    sipo_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (syn_vec)
    );

    sipo_shift_reg #(
        .CHANNELS (CHANNELS)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (syn_bus.sclk),
        .sdi_s  (syn_bus.sdi),
        .sr_q   (sr_q),
        .sdo    (sdo)
    );

    sipo_hold_bank #(
        .CHANNELS (CHANNELS)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .le_s   (syn_bus.le),
        .sr_q   (sr_q),
        .held_q (held_q)
    );

    sipo_out_stage #(
        .CHANNELS       (CHANNELS),
        .FILL_ASCENDING (FILL_ASCENDING)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .blank_n (blank_n),
        .pol     (pol),
        .held_q  (held_q),
        .out_on  (out_on)
    );

    // R9: reset leaves the chaining output low on the next edge
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (sdo == 1'b0 && out_on == '0));

endmodule

// File: tb/test_sipo_channel_driver.sv
module test_sipo_channel_driver;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         le = 1'b0;
    logic         blank_n = 1'b1;
    logic         pol = 1'b1;
    logic [N-1:0] out_asc;
    logic [N-1:0] out_desc;
    logic         sdo_asc;
    logic         sdo_desc;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sipo_channel_driver #(.CHANNELS(N), .FILL_ASCENDING(1'b1)) i_sipo_channel_driver (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .le(le),
        .blank_n(blank_n), .pol(pol), .out_on(out_asc), .sdo(sdo_asc));

    sipo_channel_driver #(.CHANNELS(N), .FILL_ASCENDING(1'b0)) i_sipo_channel_driver_rev (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .le(le),
        .blank_n(blank_n), .pol(pol), .out_on(out_desc), .sdo(sdo_desc));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bits[i] is the i-th bit shifted in
    function automatic logic [N-1:0] asc_map(input logic [N-1:0] bits);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = bits[N-1-k];
        return r;
    endfunction

    function automatic logic [N-1:0] apply(input logic [N-1:0] w, input logic b, input logic p);
        if (!b) return p ? '0 : '1;
        return p ? w : ~w;
    endfunction

    task automatic shift_bit(input logic b);
        sdi  = b;
        sclk = 1'b1;
        cyc(4);
        sclk = 1'b0;
        cyc(4);
    endtask

    // toggle_ctl wiggles le-unrelated controls during shifting (R3)
    task automatic shift_word(input logic [N-1:0] bits, input bit toggle_ctl);
        for (int i = 0; i < N; i++) begin
            if (toggle_ctl) begin
                blank_n = i[0];
                pol     = i[1];
            end
            shift_bit(bits[i]);
        end
    endtask

    task automatic load_pulse();
        le = 1'b1;
        cyc(4);
        le = 1'b0;
        cyc(4);
    endtask

    task automatic check_modes(input string tag, input logic [N-1:0] bits);
        for (int m = 0; m < 4; m++) begin
            blank_n = m[1];
            pol     = m[0];
            cyc(2);
            check({tag, " asc R5 R6 R7 R8"}, out_asc,  apply(asc_map(bits), m[1], m[0]));
            check({tag, " desc R5 R6 R7 R8"}, out_desc, apply(bits, m[1], m[0]));
        end
    endtask

    initial begin
        logic [N-1:0] words [6];
        logic [N-1:0] prev;
        logic [N-1:0] nxt;
        words[0] = '0;
        words[1] = '1;
        words[2] = 32'hAAAA_5555;
        words[3] = 32'h0000_0001;
        words[4] = $urandom(7);
        words[5] = $urandom;

        // R9: reset state
        cyc(3);
        check("R9 out asc", out_asc, '0);
        check("R9 out desc", out_desc, '0);
        check("R9 sdo", {31'b0, sdo_asc}, '0);
        rst = 1'b0;
        cyc(2);

        // main sweep: each word under all four control settings
        for (int w = 0; w < 6; w++) begin
            shift_word(words[w], 1'b0);
            check("R2 sdo after full word", {31'b0, sdo_asc}, {31'b0, words[w][0]});
            check("R1 sdo desc", {31'b0, sdo_desc}, {31'b0, words[w][0]});
            load_pulse();
            check_modes("sweep", words[w]);
        end

        // R2: one more shift exposes the second bit
        shift_bit(1'b0);
        check("R2 second bit on sdo", {31'b0, sdo_asc}, {31'b0, words[5][1]});

        // R3 + R4: shift with controls toggling and le low; outputs stay on old word
        prev = words[5];
        blank_n = 1'b1; pol = 1'b1;
        shift_word(words[2], 1'b0);
        load_pulse();
        prev = words[2];
        nxt  = 32'h1234_5678;
        shift_word(nxt, 1'b1);
        blank_n = 1'b1; pol = 1'b1;
        cyc(2);
        check("R4 hold while le low asc", out_asc, asc_map(prev));
        check("R4 hold while le low desc", out_desc, prev);
        check("R3 sdo unaffected by controls", {31'b0, sdo_asc}, {31'b0, nxt[0]});

        // R10: load latency, exactly the fourth edge after le rises
        le = 1'b1;
        cyc(3);
        check("R10 not before 4th edge", out_desc, prev);
        cyc(1);
        check("R10 at 4th edge", out_desc, nxt);
        check("R3 R8 shifted contents asc", out_asc, asc_map(nxt));
        le = 1'b0;
        cyc(4);

        // R10: control change seen at the first edge
        pol = 1'b0;
        cyc(1);
        check("R10 polarity one edge R7", out_desc, ~nxt);
        blank_n = 1'b0;
        cyc(1);
        check("R10 blank one edge R5", out_desc, '1);
        pol = 1'b1;
        cyc(1);
        check("R10 blank one edge R6", out_asc, '0);

        // R1: sclk held without a falling edge changes nothing
        blank_n = 1'b1;
        sclk = 1'b1; sdi = ~nxt[1];
        cyc(10);
        load_pulse();
        check("R1 no shift without falling edge", out_desc, nxt);
        sclk = 1'b0;
        cyc(4);

        // R9: reset mid-operation clears everything
        rst = 1'b1;
        cyc(2);
        check("R9 reset clears asc", out_asc, '0);
        check("R9 reset clears desc", out_desc, '0);
        rst = 1'b0;
        load_pulse();
        check("R9 register cleared", out_asc, '0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule